// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a read cache that keeps the single-probe hit path of a direct-mapped array but reduces conflict misses by giving every line a second home. The line array is split into a lower half and an upper half. Each address has a primary slot, chosen by its index bits, and a partner slot in the opposite half. The partner slot is the same index with its top bit inverted. A request that hits its primary slot is answered in one cycle. A request that misses there probes the partner slot in the next cycle. A hit in the partner slot is a slow hit. A miss in both slots fetches the word from the next memory level.

On a slow hit the two slots exchange contents, so the line just used becomes a fast hit next time. On a refill the new line takes the primary slot, the line that was there moves to the partner slot, and the previous partner line is dropped. Each stored key holds the upper address tag plus the top index bit. Two addresses that share a tag but belong to opposite halves therefore never match each other's lines. Only one request is in flight at a time. The request side pauses while the second probe or a refill is under way.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low. The first access to any address is therefore a miss.
- R2: A request whose primary slot (index = `req_addr[IDX_W-1:0]`) holds its line produces `rsp_valid` one cycle after acceptance, with `rsp_status` = 2'b00 and the cached word. `req_ready` stays high, so fast hits can be issued back to back.
- R3: A request that misses its primary slot but finds its line in the partner slot (index with its MSB inverted) responds two cycles after acceptance with `rsp_status` = 2'b01 and the cached word.
- R4: On a slow hit the primary and partner slots swap contents. The next access to the same address is a fast hit, and the line formerly in the primary slot is found in the partner slot.
- R5: A request that misses both slots raises `mem_req_valid` with `mem_req_addr` equal to the request address. The cache holds both signals until a cycle in which `mem_rsp_valid` is high. It responds one cycle later with `rsp_status` = 2'b10 and `mem_rsp_data`.
- R6: On a refill the new line is written into the primary slot and the previous primary line moves to the partner slot. The previous partner line is discarded.
- R7: The stored key includes the top index bit. A line sitting in a slot never hits for an address whose primary slot is in the other half, even when the upper tags are equal.
- R8: `req_ready` is low from the cycle after a request misses its primary slot until the cycle in which its response is presented.
- R9: Each accepted request produces exactly one `rsp_valid` pulse of one cycle, and `rsp_status` is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Returned word |
| rsp_status | output | 2 | 00 fast hit, 01 slow hit, 10 miss |
| mem_req_valid | output | 1 | Refill request to next level, held until answered |
| mem_req_addr | output | ADDR_W | Word address to fetch |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
The bound checker watches the timing classes on every cycle:
- a fast-hit response must follow an acceptance by exactly one cycle, and a slow hit by exactly two;
- a miss response must follow a refill handshake;
- the refill request must stay stable until it is answered;
- `req_ready` must be low while a refill is pending;
- no illegal status code may appear.

Where lines actually live can only be shown by the bench's directed scenarios, which are ordered so that earlier accesses leave a known arrangement. These scenarios cover the swap on a slow hit, the move of the displaced primary line into the partner slot, the loss of the old partner line, and the rejection of a same-tag line from the other half.

// File: rtl/pac_pkg.sv
package pac_pkg;
   typedef enum logic [1:0] {
      ST_FAST = 2'b00,
      ST_SLOW = 2'b01,
      ST_MISS = 2'b10
   } rsp_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_ALT  = 2'b01,
      PH_FILL = 2'b10
   } phase_e;
endpackage

// File: rtl/pac_store.sv
// Line array: valid bits, keys and data words, two combinational read
// ports and two write ports that always target different slots.
module pac_store #(
   parameter int IDX_W  = 4,
   parameter int KEY_W  = 13,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_idx,
   output logic              a_vld,
   output logic [KEY_W-1:0]  a_key,
   output logic [DATA_W-1:0] a_data,
   input  logic [IDX_W-1:0]  b_idx,
   output logic              b_vld,
   output logic [KEY_W-1:0]  b_key,
   output logic [DATA_W-1:0] b_data,
   input  logic              w0_en,
   input  logic [IDX_W-1:0]  w0_idx,
   input  logic              w0_vld,
   input  logic [KEY_W-1:0]  w0_key,
   input  logic [DATA_W-1:0] w0_data,
   input  logic              w1_en,
   input  logic [IDX_W-1:0]  w1_idx,
   input  logic              w1_vld,
   input  logic [KEY_W-1:0]  w1_key,
   input  logic [DATA_W-1:0] w1_data
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0] vld_q;
   logic [KEY_W-1:0]  key_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (w0_en && w0_idx == IDX_W'(i)) begin
               vld_q[i] <= w0_vld;
            end else if (w1_en && w1_idx == IDX_W'(i)) begin
               vld_q[i] <= w1_vld;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LINES; i++) begin
         if (w0_en && w0_idx == IDX_W'(i)) begin
            key_q[i]  <= w0_key;
            data_q[i] <= w0_data;
         end else if (w1_en && w1_idx == IDX_W'(i)) begin
            key_q[i]  <= w1_key;
            data_q[i] <= w1_data;
         end
      end
   end

   assign a_vld  = vld_q[a_idx];
   assign a_key  = key_q[a_idx];
   assign a_data = data_q[a_idx];
   assign b_vld  = vld_q[b_idx];
   assign b_key  = key_q[b_idx];
   assign b_data = data_q[b_idx];
endmodule

// File: rtl/pac_match.sv
// Key comparator for one probed slot.
module pac_match #(
   parameter int KEY_W = 13
) (
   input  logic             slot_vld,
   input  logic [KEY_W-1:0] slot_key,
   input  logic [KEY_W-1:0] want_key,
   output logic             hit
);
   assign hit = slot_vld && (slot_key == want_key);
endmodule

// File: rtl/pac_ctrl.sv
// Probe sequencer and response register.
module pac_ctrl
   import pac_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic              hit_pri,
   input  logic              hit_alt,
   input  logic [DATA_W-1:0] pri_data,
   input  logic [DATA_W-1:0] alt_data,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output phase_e            phase,
   output logic              req_ready,
   output logic              mem_req_valid,
   output logic              do_swap,
   output logic              do_fill,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [1:0]        rsp_status
);
   phase_e    phase_q;
   rsp_kind_e kind_q;

   always_comb begin
      req_ready     = (phase_q == PH_IDLE);
      mem_req_valid = (phase_q == PH_FILL);
      do_swap       = (phase_q == PH_ALT) && hit_alt;
      do_fill       = (phase_q == PH_FILL) && mem_rsp_valid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         kind_q    <= ST_FAST;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req_fire) begin
                  if (hit_pri) begin
                     rsp_valid <= 1'b1;
                     kind_q    <= ST_FAST;
                     rsp_data  <= pri_data;
                  end else begin
                     phase_q <= PH_ALT;
                  end
               end
            end
            PH_ALT: begin
               if (hit_alt) begin
                  rsp_valid <= 1'b1;
                  kind_q    <= ST_SLOW;
                  rsp_data  <= alt_data;
                  phase_q   <= PH_IDLE;
               end else begin
                  phase_q <= PH_FILL;
               end
            end
            PH_FILL: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  kind_q    <= ST_MISS;
                  rsp_data  <= mem_rsp_data;
                  phase_q   <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase      = phase_q;
   assign rsp_status = kind_q;
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
   import pac_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [1:0]        rsp_status,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int KEY_W = TAG_W + 1;
   localparam logic [IDX_W-1:0] HALF_MASK = IDX_W'(1) << (IDX_W - 1);

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("IDX_W must be at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed IDX_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   phase_e            phase;
   logic              req_fire;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] look_addr;
   logic [IDX_W-1:0]  look_idx;
   logic [IDX_W-1:0]  alt_idx;
   logic [KEY_W-1:0]  want_key;

   logic              a_vld, b_vld;
   logic [KEY_W-1:0]  a_key, b_key;
   logic [DATA_W-1:0] a_data, b_data;
   logic [1:0]        hit_vec;
   logic              do_swap, do_fill;

   logic              w0_en, w0_vld, w1_en, w1_vld;
   logic [KEY_W-1:0]  w0_key, w1_key;
   logic [DATA_W-1:0] w0_data, w1_data;

   assign req_fire  = req_valid && req_ready;
   assign look_addr = (phase == PH_IDLE) ? req_addr : addr_q;
   assign look_idx  = look_addr[IDX_W-1:0];
   assign alt_idx   = look_idx ^ HALF_MASK;
   assign want_key  = {look_addr[ADDR_W-1:IDX_W], look_idx[IDX_W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (req_fire) begin
         addr_q <= req_addr;
      end
   end

   pac_store #(
      .IDX_W (IDX_W),
      .KEY_W (KEY_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_idx  (look_idx),
      .a_vld  (a_vld),
      .a_key  (a_key),
      .a_data (a_data),
      .b_idx  (alt_idx),
      .b_vld  (b_vld),
      .b_key  (b_key),
      .b_data (b_data),
      .w0_en  (w0_en),
      .w0_idx (look_idx),
      .w0_vld (w0_vld),
      .w0_key (w0_key),
      .w0_data(w0_data),
      .w1_en  (w1_en),
      .w1_idx (alt_idx),
      .w1_vld (w1_vld),
      .w1_key (w1_key),
      .w1_data(w1_data)
   );

   generate
      for (genvar p = 0; p < 2; p++) begin : g_probe
         pac_match #(.KEY_W(KEY_W)) u_match (
            .slot_vld(p == 0 ? a_vld : b_vld),
            .slot_key(p == 0 ? a_key : b_key),
            .want_key(want_key),
            .hit     (hit_vec[p])
         );
      end
   endgenerate

   pac_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_fire     (req_fire),
      .hit_pri      (hit_vec[0]),
      .hit_alt      (hit_vec[1]),
      .pri_data     (a_data),
      .alt_data     (b_data),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .phase        (phase),
      .req_ready    (req_ready),
      .mem_req_valid(mem_req_valid),
      .do_swap      (do_swap),
      .do_fill      (do_fill),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_status   (rsp_status)
   );

   // Primary slot takes the partner line (swap) or the new line (refill);
   // the partner slot always takes the old primary line.
   always_comb begin
      w0_en   = do_swap || do_fill;
      w0_vld  = do_fill ? 1'b1         : b_vld;
      w0_key  = do_fill ? want_key     : b_key;
      w0_data = do_fill ? mem_rsp_data : b_data;
      w1_en   = do_swap || do_fill;
      w1_vld  = a_vld;
      w1_key  = a_key;
      w1_data = a_data;
   end

   assign mem_req_addr = addr_q;
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [1:0]        rsp_status,
   input logic              mem_req_valid,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid,
   input logic [DATA_W-1:0] mem_rsp_data
);
   logic unused_data;
   assign unused_data = ^mem_rsp_data;

   AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'b00) |-> $past(req_valid && req_ready)); // R2
   AST_SLOW_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'b01) |-> $past(req_valid && req_ready, 2)); // R3
   AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R5
   AST_MISS_AFTER_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'b10) |-> $past(mem_req_valid && mem_rsp_valid)); // R5
   AST_BUSY_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready); // R8
   AST_READY_AT_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready); // R8
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_status != 2'b11)); // R9
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != 2'b00) |=> !(rsp_valid && rsp_status != 2'b00)); // R9
endmodule

bind pseudo_assoc_cache pac_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .rsp_status   (rsp_status),
   .mem_req_valid(mem_req_valid),
   .mem_req_addr (mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid),
   .mem_rsp_data (mem_rsp_data)
);

// File: tb/sim_pseudo_assoc_cache.sv
module sim_pseudo_assoc_cache;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W  = 16;
   localparam int DATA_W  = 32;
   localparam int IDX_W   = 4;
   localparam int MEM_LAT = 3;
   localparam logic [1:0] K_FAST = 2'b00;
   localparam logic [1:0] K_SLOW = 2'b01;
   localparam logic [1:0] K_MISS = 2'b10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_data;
   logic [1:0]        rsp_status;
   logic              mem_req_valid;
   logic [ADDR_W-1:0] mem_req_addr;
   logic              mem_rsp_valid;
   logic [DATA_W-1:0] mem_rsp_data;

   int n_cmp  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pseudo_assoc_cache #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_status   (rsp_status),
      .mem_req_valid(mem_req_valid),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data)
   );

   function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
      return DATA_W'({a ^ 16'h5A3C, a});
   endfunction

   // Next-level memory: answers MEM_LAT cycles after a request appears.
   initial begin
      int cnt;
      cnt = 0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            cnt = 0;
         end else if (mem_req_valid) begin
            cnt++;
            if (cnt == MEM_LAT) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem_word(mem_req_addr);
            end
         end else begin
            cnt = 0;
         end
      end
   end

   task automatic check(input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] kind,
                         input string rq);
      int  lat;
      int  exp_lat;
      bit  busy_ok;
      @(negedge clk);
      check("R8", "ready before request", 64'(req_ready), 64'(1));
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      busy_ok = 1'b1;
      while (!rsp_valid && lat < 64) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      exp_lat = (kind == K_FAST) ? 1 : (kind == K_SLOW) ? 2 : MEM_LAT + 2;
      check(rq, "rsp_valid", 64'(rsp_valid), 64'(1));
      check(rq, "status", 64'(rsp_status), 64'(kind));
      check(rq, "data", 64'(rsp_data), 64'(mem_word(a)));
      check(rq, "latency", 64'(lat), 64'(exp_lat));
      if (kind != K_FAST) begin
         check("R8", "ready low while busy", 64'(busy_ok), 64'(1));
      end
      check("R8", "ready at response", 64'(req_ready), 64'(1));
      @(negedge clk);
      check("R9", "single pulse", 64'(rsp_valid), 64'(0));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ready after reset", 64'(req_ready), 64'(1));
      check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
      check("R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'(0));
   endtask

   task automatic t_refill_request();
      // R5: request address presented and held
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 16'h0047;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check("R5", "mem_req_valid", 64'(mem_req_valid), 64'(1));
      check("R5", "mem_req_addr", 64'(mem_req_addr), 64'(16'h0047));
      while (!rsp_valid) @(negedge clk);
      check("R5", "miss status", 64'(rsp_status), 64'(K_MISS));
      check("R5", "refill data", 64'(rsp_data), 64'(mem_word(16'h0047)));
   endtask

   task automatic t_back_to_back(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      check("R2", "first rsp_valid", 64'(rsp_valid), 64'(1));
      check("R2", "first status", 64'(rsp_status), 64'(K_FAST));
      check("R2", "first data", 64'(rsp_data), 64'(mem_word(a)));
      check("R2", "ready stays high", 64'(req_ready), 64'(1));
      req_addr = b;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R2", "second rsp_valid", 64'(rsp_valid), 64'(1));
      check("R2", "second data", 64'(rsp_data), 64'(mem_word(b)));
      @(negedge clk);
      check("R9", "no extra pulse", 64'(rsp_valid), 64'(0));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      // A, B share primary slot 3; C shares A's tag but maps to slot 11
      t_reset();
      access(16'h0013, K_MISS, "R1");  // cold: all lines invalid
      access(16'h0013, K_FAST, "R2");
      access(16'h0023, K_MISS, "R6");  // B primary, A pushed to slot 11
      access(16'h0013, K_SLOW, "R3");  // A found in partner
      access(16'h0013, K_FAST, "R4");  // swapped into primary
      access(16'h0023, K_SLOW, "R4");  // B now in partner
      access(16'h001B, K_MISS, "R7");  // A in slot 11 must not match C
      access(16'h0013, K_FAST, "R6");  // A displaced into slot 3
      t_back_to_back(16'h0013, 16'h001B);
      access(16'h0023, K_MISS, "R6");  // B was discarded
      access(16'h0013, K_SLOW, "R6");  // A moved to partner by refill
      t_refill_request();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule